// File: doc/BRIEF.md
# Delayed-Step Noise Shift Register

This block produces the noise voice of a digital oscillator. It holds a 23-bit shift register with linear feedback. The register advances one position each time the oscillator reports that its phase accumulator bit 19 has gone from 0 to 1. That advance waits a fixed two-cycle pipeline. Eight register bits, spread across the word, are routed to the top eight bits of a 12-bit noise sample. The four low sample bits are tied to zero.

Two side paths change the register outside normal stepping. The first is the oscillator's test input. While test is held, stepping stops and a countdown runs. When the countdown expires, the whole register is refilled with ones. The second is a write-back path for mixed waveforms. When noise is mixed with other waveforms, the final 12-bit mixed output is fed back. Any zero bit in that output clears the matching tap bit, so mixed waveforms that include noise fade to silence after a few steps.

Top module: `noise_lfsr`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) loads all 23 register bits with one, cancels any pending step and stops the test countdown, so that after that edge `noise_o` reads 0xFF0.
- R2: A step shifts the register left by one place. The bit leaving position 22 is dropped, and the new bit 0 is the XOR of the old bits 22 and 17.
- R3: If `rise_i` is sampled high at edge k, and neither `rise_i` nor `test_i` is sampled high at edge k+1 or k+2, the step is taken at edge k+2. If `rise_i` is sampled high again while a step is pending, the delay restarts from that edge and the earlier step is abandoned.
- R4: When no step is pending and `test_i` and `combined_i` are low, the register and `noise_o` keep their values across the edge.
- R5: `noise_o[11:4]` carry register bits 20, 18, 14, 11, 9, 5, 2 and 0, in that order from bit 11 down. `noise_o[3:0]` are always zero.
- R6: While `test_i` is high, no step is taken, `rise_i` is ignored and any pending step is cancelled. Apart from the R7 refill and the R8 write-back, the register holds its value.
- R7: At the RESET_CYCLES-th edge after the edge that first samples `test_i` high, with `test_i` still high, the register is loaded with 0x7FFFFF. Every low-to-high change of `test_i` restarts the count. Dropping `test_i` before expiry abandons the refill.
- R8: At any edge where `combined_i` is high, the value about to be stored (after any step or refill) has each tap bit ANDed with the matching bit of `wave_i[11:4]`, using the R5 pairing. So after that edge `noise_o[11:4]` has no one bit where `wave_i[11:4]` had a zero.
- R9: When `combined_i` is low, `wave_i` has no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rise_i | input | 1 | One-cycle strobe: accumulator bit 19 rose this cycle |
| test_i | input | 1 | Oscillator test level; freezes stepping and starts the refill count |
| combined_i | input | 1 | Noise is mixed with another waveform; enables write-back |
| wave_i | input | 12 | Final mixed waveform sample used for write-back |
| noise_o | output | 12 | Noise sample: eight tap bits on top, low four bits zero |

## Verification
The bench starts from the all-ones state and sends isolated rise strobes. This shows whether the step lands two edges later and not one or three, and whether the feedback produces the expected tap pattern. Strobes one edge apart test the restart rule, and a reset during a pending step shows that the pending step is dropped. Long and short test pulses separate a correct refill edge from an off-by-one or a count that is not restarted. Write-back with all-zero, all-one and random mixed samples, plus random `wave_i` with write-back disabled, shows that clearing happens only through the enabled path. A long random stretch, from a fixed seed, mixes all of these events against the bench's own register model.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;

   // register length and feedback positions (fixed by the noise sequence)
   localparam int LFSR_W   = 23;
   localparam int FB_HI    = 22;
   localparam int FB_LO    = 17;
   // number of register bits exposed on the sample
   localparam int TAP_N    = 8;

   // register bit feeding sample bit (OUT_W - TAP_N + i), i = 0 is the lowest tap
   function automatic int tap_pos(input int i);
      case (i)
         0:       return 0;
         1:       return 2;
         2:       return 5;
         3:       return 9;
         4:       return 11;
         5:       return 14;
         6:       return 18;
         default: return 20;
      endcase
   endfunction

endpackage

// File: rtl/noise_step_pipe.sv
module noise_step_pipe #(
   parameter int DELAY = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic hold,
   input  logic rise,
   output logic step
);
   localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
   localparam logic [CW-1:0] LOAD = CW'(DELAY);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || hold) begin
         cnt_q <= '0;
      end else if (rise) begin
         cnt_q <= LOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // a fresh strobe takes priority over a step about to fire
   assign step = !hold && !rise && (cnt_q == CW'(1));

endmodule

// File: rtl/noise_test_timer.sv
module noise_test_timer #(
   parameter int CYCLES = 24
) (
   input  logic clk,
   input  logic rst,
   input  logic test,
   output logic expire
);
   localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYCLES);

   logic [CW-1:0] cnt_q;
   logic          test_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         test_q <= 1'b0;
      end else begin
         test_q <= test;
         if (!test) begin
            cnt_q <= '0;
         end else if (!test_q) begin
            cnt_q <= LOAD;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign expire = test && test_q && (cnt_q == CW'(1));

endmodule

// File: rtl/noise_lfsr_core.sv
module noise_lfsr_core
   import noise_lfsr_pkg::*;
#(
   parameter int W  = LFSR_W,
   parameter int HI = FB_HI,
   parameter int LO = FB_LO
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   input  logic             load_ones,
   input  logic             wb_en,
   input  logic [TAP_N-1:0] wb_bits,
   output logic [W-1:0]     state_o
);
   logic [W-1:0] q;
   logic [W-1:0] keep_mask;
   logic [W-1:0] moved;
   logic [W-1:0] nxt;

   // clear mask: tap positions follow wb_bits, all other positions pass
   for (genvar b = 0; b < W; b++) begin : g_mask
      logic hit;
      logic val;
      always_comb begin
         hit = 1'b0;
         val = 1'b1;
         for (int t = 0; t < TAP_N; t++) begin
            if (tap_pos(t) == b) begin
               hit = 1'b1;
               val = wb_bits[t];
            end
         end
      end
      assign keep_mask[b] = hit ? val : 1'b1;
   end

   assign moved = {q[W-2:0], q[HI] ^ q[LO]};

   always_comb begin
      if (load_ones) begin
         nxt = '1;
      end else if (step) begin
         nxt = moved;
      end else begin
         nxt = q;
      end
      if (wb_en) begin
         nxt = nxt & keep_mask;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '1;
      end else begin
         q <= nxt;
      end
   end

   assign state_o = q;

endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
   import noise_lfsr_pkg::*;
#(
   parameter int OUT_W        = 12,
   parameter int STEP_DELAY   = 2,
   parameter int RESET_CYCLES = 24
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rise_i,
   input  logic             test_i,
   input  logic             combined_i,
   input  logic [OUT_W-1:0] wave_i,
   output logic [OUT_W-1:0] noise_o
);
   localparam int LOW_W = OUT_W - TAP_N;

   if (OUT_W < TAP_N) begin : g_bad_width
      $error("noise_lfsr: OUT_W must be at least TAP_N");
   end
   if (STEP_DELAY < 1) begin : g_bad_delay
      $error("noise_lfsr: STEP_DELAY must be at least 1");
   end
   if (RESET_CYCLES < 1) begin : g_bad_cycles
      $error("noise_lfsr: RESET_CYCLES must be at least 1");
   end

   logic              step;
   logic              refill;
   logic [TAP_N-1:0]  wb_bits;
   logic [LFSR_W-1:0] state;
   logic [TAP_N-1:0]  taps;

   noise_step_pipe #(.DELAY(STEP_DELAY)) pipe_i (
      .clk  (clk),
      .rst  (rst),
      .hold (test_i),
      .rise (rise_i),
      .step (step)
   );

   noise_test_timer #(.CYCLES(RESET_CYCLES)) timer_i (
      .clk    (clk),
      .rst    (rst),
      .test   (test_i),
      .expire (refill)
   );

   assign wb_bits = wave_i[OUT_W-1 -: TAP_N];

   noise_lfsr_core #(.W(LFSR_W), .HI(FB_HI), .LO(FB_LO)) core_i (
      .clk       (clk),
      .rst       (rst),
      .step      (step),
      .load_ones (refill),
      .wb_en     (combined_i),
      .wb_bits   (wb_bits),
      .state_o   (state)
   );

   for (genvar t = 0; t < TAP_N; t++) begin : g_tap
      assign taps[t] = state[tap_pos(t)];
   end

   if (LOW_W > 0) begin : g_pad
      assign noise_o = {taps, {LOW_W{1'b0}}};
   end else begin : g_nopad
      assign noise_o = taps;
   end

endmodule

// File: rtl/noise_lfsr_chk.sv
module noise_lfsr_chk
   import noise_lfsr_pkg::*;
#(
   parameter int OUT_W        = 12,
   parameter int STEP_DELAY   = 2,
   parameter int RESET_CYCLES = 24
) (
   input logic             clk,
   input logic             rst,
   input logic             rise_i,
   input logic             test_i,
   input logic             combined_i,
   input logic [OUT_W-1:0] wave_i,
   input logic [OUT_W-1:0] noise_o
);
   localparam logic [OUT_W-1:0] ONES_OUT = {{TAP_N{1'b1}}, {(OUT_W-TAP_N){1'b0}}};
   localparam int TW = $clog2(RESET_CYCLES + 2);

   logic [STEP_DELAY-1:0] hist_q;
   logic [TW-1:0]         tcnt_q;
   logic                  rst_q;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) begin
         hist_q <= '0;
         tcnt_q <= '0;
      end else begin
         hist_q <= (hist_q << 1) | STEP_DELAY'(rise_i);
         if (!test_i) begin
            tcnt_q <= '0;
         end else if (tcnt_q != TW'(RESET_CYCLES + 1)) begin
            tcnt_q <= tcnt_q + 1'b1;
         end
      end
   end

   // R1: the edge after a reset edge shows the all-ones sample
   always @(posedge clk) begin
      if (rst_q === 1'b1) begin
         p_reset_ones_r1: assert (noise_o == ONES_OUT)
            else $error("reset did not load all ones");
      end
   end

   // R4
   p_no_step_r4: assert property (@(posedge clk) disable iff (rst)
      (!test_i && !combined_i && !hist_q[STEP_DELAY-1]) |=> $stable(noise_o));

   // R6
   p_test_freeze_r6: assert property (@(posedge clk) disable iff (rst)
      (test_i && !combined_i && tcnt_q != TW'(RESET_CYCLES)) |=> $stable(noise_o));

   // R7
   p_test_refill_r7: assert property (@(posedge clk) disable iff (rst)
      (test_i && !combined_i && tcnt_q == TW'(RESET_CYCLES)) |=> (noise_o == ONES_OUT));

   // R8
   p_writeback_and_r8: assert property (@(posedge clk) disable iff (rst)
      combined_i |=> ((noise_o[OUT_W-1 -: TAP_N] & ~$past(wave_i[OUT_W-1 -: TAP_N])) == '0));

   // R5: low sample bits stay grounded
   p_low_zero_r5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (noise_o[OUT_W-TAP_N-1:0] == '0));

endmodule

bind noise_lfsr noise_lfsr_chk #(
   .OUT_W        (OUT_W),
   .STEP_DELAY   (STEP_DELAY),
   .RESET_CYCLES (RESET_CYCLES)
) chk_i (.*);

// File: tb/noise_lfsr_tb_top.sv
`timescale 1ns/1ps
module noise_lfsr_tb_top;
   localparam int RC = 24;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        rise = 1'b0;
   logic        test = 1'b0;
   logic        comb = 1'b0;
   logic [11:0] wave = '0;
   logic [11:0] noise;

   always #4 clk = ~clk;

   noise_lfsr #(.OUT_W(12), .STEP_DELAY(2), .RESET_CYCLES(RC)) dut_i (
      .clk        (clk),
      .rst        (rst),
      .rise_i     (rise),
      .test_i     (test),
      .combined_i (comb),
      .wave_i     (wave),
      .noise_o    (noise)
   );

   // bench model state
   logic [22:0] m_s = '1;
   int          m_pend = 0;
   int          m_tc = 0;
   logic        m_tprev = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   function automatic logic [11:0] sample_of(input logic [22:0] s);
      return {s[20], s[18], s[14], s[11], s[9], s[5], s[2], s[0], 4'h0};
   endfunction

   function automatic logic [22:0] wb_mask(input logic [11:0] w);
      logic [22:0] m;
      m = '1;
      m[20] = w[11]; m[18] = w[10]; m[14] = w[9]; m[11] = w[8];
      m[9]  = w[7];  m[5]  = w[6];  m[2]  = w[5]; m[0]  = w[4];
      return m;
   endfunction

   task automatic model_edge();
      logic [22:0] n;
      if (rst) begin
         m_s = '1; m_pend = 0; m_tc = 0; m_tprev = 1'b0;
         return;
      end
      n = m_s;
      if (test) begin
         m_pend = 0;
         if (!m_tprev) m_tc = RC;
         else if (m_tc != 0) begin
            m_tc--;
            if (m_tc == 0) n = '1;
         end
      end else begin
         m_tc = 0;
         if (rise) m_pend = 2;
         else if (m_pend != 0) begin
            m_pend--;
            if (m_pend == 0) n = {m_s[21:0], m_s[22] ^ m_s[17]};
         end
      end
      if (comb) n = n & wb_mask(wave);
      m_tprev = test;
      m_s = n;
   endtask

   // one clock: inputs already driven; update model at the edge, check at the falling edge
   task automatic cyc(input string tag);
      logic [11:0] exp;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      exp = sample_of(m_s);
      checks++;
      if (noise !== exp) begin
         errors++;
         $display("FAIL %s noise_o=%h expected %h", tag, noise, exp);
      end
   endtask

   task automatic idle(input int n, input string tag);
      rise = 0; test = 0; comb = 0;
      for (int i = 0; i < n; i++) cyc(tag);
   endtask

   task automatic pulse_rise(input string tag);
      rise = 1; cyc(tag);
      rise = 0; cyc(tag); cyc(tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R1 reset state
      rst = 1; cyc("R1"); cyc("R1");
      rst = 0;
      idle(3, "R4");
      // R3: first step from all ones gives 0xFE0 two edges after the strobe
      pulse_rise("R3");
      if (noise !== 12'hFE0) begin
         errors++;
         $display("FAIL R3 noise_o=%h expected %h", noise, 12'hFE0);
      end
      checks++;
      // R2 / R5: many steps, spaced
      for (int i = 0; i < 40; i++) begin
         pulse_rise("R2");
         cyc("R5");
      end
      // R3 restart: strobes on consecutive edges
      for (int i = 0; i < 6; i++) begin
         rise = 1; cyc("R3");
      end
      rise = 0; idle(4, "R3");
      // R1 clears a pending step
      rise = 1; cyc("R3");
      rise = 0; rst = 1; cyc("R1");
      rst = 0; idle(4, "R1");
      // move away from all ones
      for (int i = 0; i < 10; i++) pulse_rise("R2");
      // R6: test cancels a pending step, rises ignored
      rise = 1; cyc("R6");
      rise = 1; test = 1; cyc("R6");
      for (int i = 0; i < 5; i++) cyc("R6");
      // short drop abandons the count, new pulse restarts it (R7)
      test = 0; rise = 0; cyc("R7");
      test = 1;
      for (int i = 0; i < RC + 3; i++) cyc("R7");
      test = 0; idle(3, "R7");
      // R8: write-back with zeros, ones and random
      for (int i = 0; i < 10; i++) pulse_rise("R2");
      comb = 1; wave = 12'hFFF; cyc("R8");
      wave = 12'h5A0; cyc("R8");
      wave = 12'h000; cyc("R8");
      comb = 0; cyc("R8");
      if (noise !== 12'h000) begin
         errors++;
         $display("FAIL R8 noise_o=%h expected %h", noise, 12'h000);
      end
      checks++;
      rst = 1; cyc("R1"); rst = 0;
      // R9: wave ignored with write-back disabled
      for (int i = 0; i < 20; i++) begin
         wave = 12'($urandom); cyc("R9");
      end
      // random mix
      for (int i = 0; i < 6000; i++) begin
         int r;
         r = int'($urandom % 1000);
         rst  = (r < 2);
         rise = ($urandom % 4) == 0;
         if (($urandom % 60) == 0) test = ~test;
         comb = ($urandom % 20) == 0;
         wave = 12'($urandom) | (($urandom % 2) == 0 ? 12'hFF0 : 12'h000);
         cyc(test ? "R7" : (comb ? "R8" : "R3"));
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog run did not complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule